// File: doc/BRIEF.md
# DMA Block and Repeat Counter

This block is the counting core of one DMA channel. It keeps the number of bytes left in the current block and the number of blocks left in a repeated transaction. The channel datapath gives it one strobe per byte it reads. From these strobes the block produces a block-done pulse, a transaction-done pulse and the channel-enable status.

Software loads three values through a narrow write port: the low half of the 16-bit byte count, the high half, and the 8-bit repeat count. Each half write goes into both the live count and a reload copy. When the live count runs out, it refills from that copy, so back-to-back blocks need no rewrite. A stored zero stands for the largest block. A repeat count of zero in repeat mode keeps the channel running without end. A start input enables the channel.

Top module: `dma_block_counter`

## Requirements
- R1: After reset the byte count is 0x0001, the repeat count is 0x00, chan_en is 0, and blk_done and xfer_done are 0.
- R2: A pulse on wr_cnt_lo loads cfg_data into bits [7:0] of both the live byte count and its reload copy. wr_cnt_hi does the same for bits [15:8]. wr_rep loads cfg_data into the repeat count. Each new value is visible the cycle after the write.
- R3: A byte_done strobe while chan_en is 1 lowers the byte count by one. A strobe while chan_en is 0 has no effect on any output.
- R4: The strobe that meets a byte count of 1 reloads the count with the last written value. It also raises blk_done for exactly one cycle, in the cycle after the strobe.
- R5: A byte count written as 0x0000 gives a block of 0xFFFF bytes.
- R6: With rep_mode 1 and a nonzero repeat count, each finished block lowers the repeat count by one. The block that brings it to zero clears chan_en, so a count of N runs N blocks.
- R7: With rep_mode 1 and a repeat count of zero, finished blocks never clear chan_en, and the repeat count stays zero.
- R8: With rep_mode 0, chan_en clears after one finished block and the repeat count is left unchanged.
- R9: xfer_done pulses for exactly one cycle, in the same cycle that chan_en falls from a finished transaction. It always coincides with blk_done.
- R10: A start pulse sets chan_en in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_data | input | 8 | Write data for the count registers |
| wr_cnt_lo | input | 1 | Write strobe, byte count bits [7:0] |
| wr_cnt_hi | input | 1 | Write strobe, byte count bits [15:8] |
| wr_rep | input | 1 | Write strobe, repeat count |
| start | input | 1 | Enables the channel |
| rep_mode | input | 1 | 1 selects repeated blocks |
| byte_done | input | 1 | One strobe per byte read by the channel |
| byte_cnt | output | 16 | Live byte count |
| rep_cnt | output | 8 | Live repeat count |
| chan_en | output | 1 | Channel enable status |
| blk_done | output | 1 | One-cycle pulse at block end |
| xfer_done | output | 1 | One-cycle pulse at transaction end |

## Verification
Every output is a register, so each result of a write, start or byte strobe is due one clock edge after the edge that samples it, never later. The bench drives stimulus on falling edges, holds it across one rising edge, and checks at the next falling edge. Each byte of a block therefore has its count, pulses and enable checked exactly in the cycle the requirement names. The long zero-count and high-byte blocks hold the strobe high and count rising edges until blk_done appears, so the block length is measured to the cycle.

// File: rtl/dma_block_counter.sv
module dma_block_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW/2-1:0] cfg_data,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic          wr_rep,
  input  logic          start,
  input  logic          rep_mode,
  input  logic          byte_done,
  output logic [CW-1:0] byte_cnt,
  output logic [CW/2-1:0] rep_cnt,
  output logic          chan_en,
  output logic          blk_done,
  output logic          xfer_done
);
  localparam int DW = CW / 2;

  logic [CW-1:0] cnt_q, reload_q, cnt_n, eff;
  logic [DW-1:0] rep_q;
  logic          en_q, blk_q, xfer_q;

  wire step      = en_q & byte_done;
  assign eff     = (cnt_q == '0) ? '1 : cnt_q;
  wire last_byte = step && (eff == CW'(1));
  wire finish    = last_byte && (!rep_mode || rep_q == DW'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (step) cnt_n = last_byte ? reload_q : eff - CW'(1);
    if (wr_cnt_lo) cnt_n[DW-1:0]  = cfg_data;
    if (wr_cnt_hi) cnt_n[CW-1:DW] = cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CW'(1);
      reload_q <= CW'(1);
      rep_q    <= '0;
      en_q     <= 1'b0;
      blk_q    <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (wr_cnt_lo) reload_q[DW-1:0]  <= cfg_data;
      if (wr_cnt_hi) reload_q[CW-1:DW] <= cfg_data;
      if (wr_rep)
        rep_q <= cfg_data;
      else if (last_byte && rep_mode && rep_q != '0)
        rep_q <= rep_q - DW'(1);
      if (start)       en_q <= 1'b1;
      else if (finish) en_q <= 1'b0;
      blk_q  <= last_byte;
      xfer_q <= finish & ~start;
    end
  end

  assign byte_cnt  = cnt_q;
  assign rep_cnt   = rep_q;
  assign chan_en   = en_q;
  assign blk_done  = blk_q;
  assign xfer_done = xfer_q;
endmodule

module dma_block_counter_chk #(
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW/2-1:0] cfg_data,
  input logic            wr_cnt_lo,
  input logic            wr_cnt_hi,
  input logic            wr_rep,
  input logic            start,
  input logic            rep_mode,
  input logic            byte_done,
  input logic [CW-1:0]   byte_cnt,
  input logic [CW/2-1:0] rep_cnt,
  input logic            chan_en,
  input logic            blk_done,
  input logic            xfer_done
);
  localparam int DW = CW / 2;

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_lo |=> byte_cnt[DW-1:0] == $past(cfg_data));
  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_hi |=> byte_cnt[CW-1:DW] == $past(cfg_data));
  // R2
  rep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rep |=> rep_cnt == $past(cfg_data));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && byte_done && !wr_cnt_lo && !wr_cnt_hi && byte_cnt > CW'(1)
      |=> byte_cnt == $past(byte_cnt) - CW'(1));
  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en && !wr_cnt_lo && !wr_cnt_hi |=> $stable(byte_cnt) && !blk_done);
  // R4
  blk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> $past(chan_en && byte_done));
  // R7
  forever_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && rep_mode && rep_cnt == '0 && !wr_rep |=> chan_en && rep_cnt == '0);
  // R8
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && !rep_mode && byte_done && byte_cnt == CW'(1) && !start && !wr_rep
      && !wr_cnt_lo && !wr_cnt_hi |=> !chan_en && $stable(rep_cnt) && blk_done);
  // R9
  xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $fell(chan_en) && blk_done);
  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> chan_en);
endmodule

bind dma_block_counter dma_block_counter_chk #(.CW(CW)) u_chk (.*);

// File: tb/test_dma_block_counter.sv
`timescale 1ns/1ps
module test_dma_block_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        wr_cnt_lo = 1'b0, wr_cnt_hi = 1'b0, wr_rep = 1'b0;
  logic        start = 1'b0, rep_mode = 1'b0, byte_done = 1'b0;
  logic [15:0] byte_cnt;
  logic [7:0]  rep_cnt;
  logic        chan_en, blk_done, xfer_done;
  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  dma_block_counter i_dma_block_counter (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .wr_cnt_lo(wr_cnt_lo),
    .wr_cnt_hi(wr_cnt_hi), .wr_rep(wr_rep), .start(start), .rep_mode(rep_mode),
    .byte_done(byte_done), .byte_cnt(byte_cnt), .rep_cnt(rep_cnt),
    .chan_en(chan_en), .blk_done(blk_done), .xfer_done(xfer_done));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input int sel, input int val);
    @(negedge clk);
    cfg_data = 8'(val);
    wr_cnt_lo = (sel == 0); wr_cnt_hi = (sel == 1); wr_rep = (sel == 2);
    @(negedge clk);
    wr_cnt_lo = 0; wr_cnt_hi = 0; wr_rep = 0;
  endtask

  task automatic strobe();
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic long_block(output int k);
    byte_done = 1'b1;
    k = 0;
    while (k < 70000) begin
      @(negedge clk);
      k++;
      if (blk_done) break;
    end
    byte_done = 1'b0;
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 byte_cnt", byte_cnt, 1);
    check("R1 rep_cnt", rep_cnt, 0);
    check("R1 chan_en", chan_en, 0);
    check("R1 pulses", {blk_done, xfer_done}, 0);
    @(negedge clk);
    strobe();
    check("R3 idle strobe count", byte_cnt, 1);
    check("R3 idle strobe blk", blk_done, 0);

    for (int m = 0; m < 2; m++) begin
      rep_mode = m[0];
      for (int r = 0; r < 4; r++) begin
        for (int n = 1; n < 5; n++) begin
          int blocks;
          logic forever_mode;
          forever_mode = (m == 1) && (r == 0);
          blocks = (m == 0) ? 1 : (r == 0 ? 3 : r);
          write(0, n);
          write(1, 0);
          write(2, r);
          check("R2 count write", byte_cnt, n);
          check("R2 repeat write", rep_cnt, r);
          kick();
          check("R10 start", chan_en, 1);
          for (int b = 0; b < blocks; b++) begin
            for (int j = 0; j < n; j++) begin
              logic last, endtx;
              int rexp;
              last  = (j == n - 1);
              endtx = last && (b == blocks - 1) && !forever_mode;
              strobe();
              check("R4 blk_done", blk_done, int'(last));
              check(last ? "R4 reload" : "R3 decrement", byte_cnt, last ? n : n - 1 - j);
              check("R9 xfer_done", xfer_done, int'(endtx));
              if (m == 0) check("R8 chan_en", chan_en, int'(!endtx));
              else if (r == 0) check("R7 chan_en", chan_en, 1);
              else check("R6 chan_en", chan_en, int'(!endtx));
              if (last) begin
                rexp = (m == 0) ? r : (r == 0 ? 0 : r - b - 1);
                check(m == 0 ? "R8 rep kept" : (r == 0 ? "R7 rep zero" : "R6 rep dec"),
                      rep_cnt, rexp);
              end
            end
          end
          if (!forever_mode) begin
            strobe();
            check("R3 stray strobe count", byte_cnt, n);
            check("R9 single pulse", {blk_done, xfer_done}, 0);
          end
        end
      end
    end

    rep_mode = 1'b0;
    write(0, 8'h02);
    write(1, 8'h01);
    check("R2 high half", byte_cnt, 16'h0102);
    kick();
    long_block(k);
    check("R4 block length", k, 16'h0102);
    check("R4 reload high", byte_cnt, 16'h0102);

    write(0, 0);
    write(1, 0);
    check("R5 zero written", byte_cnt, 0);
    kick();
    long_block(k);
    check("R5 zero block length", k, 16'hFFFF);
    check("R5 reload zero", byte_cnt, 0);
    check("R8 end after one block", chan_en, 0);
    check("R9 xfer with zero block", xfer_done, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule